// File: doc/BRIEF.md
# Debounced I/O Change Interrupt Generator

This block watches a bank of general-purpose pins whose sampled levels arrive on `pinIn`. Software picks for each line whether it is an input or an output, whether its interrupt is masked, and whether it is debounced. Every input line keeps an accepted level. When the synchronized pin differs from that level, the line takes the new level as a change. Without debouncing it takes it on the next clock. With debouncing it takes it only after the new level has held across a programmed number of `tick` periods. A change that is taken on an unmasked input sets a sticky pending bit. The `irq` output is high while any pending bit is set.

Software reaches the block through a small write port and a combinational read port. A bit written as 1 to the pending register clears that bit. Some mask positions can be left out when the block is built (parameter `MASK_IMPL`). Those positions store nothing and never block a line.

Top module: `ioc_irq_gen`

## Requirements
- R1: Each pin passes through two synchronizing flops. A rising or a falling change on an unmasked input line without debouncing sets that line's pending bit on the third rising clock edge after the pin changes.
- R2: A line with its direction bit set to 1 (register 0) never sets its pending bit, whatever its mask. Its accepted level follows the pin silently, so turning it back into an input raises no interrupt.
- R3: A line with its mask bit set to 1 (register 1) never sets its pending bit. Its accepted level still updates on a change, so clearing the mask later raises no interrupt for that change.
- R4: A mask position whose `MASK_IMPL` bit is 0 stores nothing, reads back as 0 and never blocks its line. By default these are positions 1 and 3, and register 1 reads back 8'hF5 after 8'hFF is written.
- R5: A line whose debounce-enable bit is 1 (register 2) takes a change only on the clock edge where `tick` is high and the new level has now been seen on PTIME ticks (register 3, 8 bits). This happens with PTIME nonzero. No pending bit is set at any earlier tick.
- R6: If a debounced line returns to its accepted level before the change is taken, its tick count restarts from zero and its accepted level stays unchanged.
- R7: A PTIME of 0, or a debounce-enable bit of 0, gives immediate behaviour as in R1, with no tick needed.
- R8: Pending bits (register 4) are sticky. Writing 1 to a bit clears it, and writing 0 leaves it alone. A new event on the same clock edge as a clear of that bit wins, and the bit stays set.
- R9: `irq` is high exactly when at least one pending bit is set.
- R10: For three clock cycles after reset, accepted levels load from the synchronized pins and no pending bit is set. A pin that is high through reset therefore raises no interrupt.
- R11: The register map is 0 direction, 1 mask, 2 debounce enable, 3 PTIME, 4 pending, 5 accepted levels (read only). Addresses 6 and 7 read as 0, and every register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | NUM_LINES | Sampled pin levels, asynchronous to clk |
| tick | input | 1 | One-cycle timebase pulse for debounce counting |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 8 | Register read data, combinational |
| pending | output | NUM_LINES | Sticky per-line pending bits |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle, the bound assertions check four things. Output-direction lines and masked lines never raise a new pending bit. No pending bit rises during the post-reset settle window. A pending bit falls only when a matching write-one clear was presented, and a debounced line raises its bit only on a tick edge. The exact cycle count from a pin edge to its pending bit, and the tick count at which a debounced change is taken, are left to the bench scenarios. So are the restart of the count after a glitch, the accepted levels read back after silent tracking, the read-back of unbuilt mask positions and set-over-clear on one edge.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  localparam int IOC_DW = 8;
  localparam int IOC_AW = 3;

  typedef enum logic [IOC_AW-1:0] {
    REG_DIR   = 3'd0,
    REG_MASK  = 3'd1,
    REG_PEN   = 3'd2,
    REG_PTIME = 3'd3,
    REG_PEND  = 3'd4,
    REG_LEVEL = 3'd5
  } regAddrE;

  // strobes from the control side to the per-line datapath
  typedef struct packed {
    logic              settling;
    logic              clrStrobe;
    logic [IOC_DW-1:0] clrBits;
  } lineStrobeS;
endpackage

// File: rtl/ioc_regs.sv
module ioc_regs
  import ioc_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int TIME_W    = 8,
  parameter logic [NUM_LINES-1:0] MASK_IMPL = '1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [IOC_AW-1:0]    wrAddr,
  input  logic [IOC_DW-1:0]    wrData,
  input  logic [IOC_AW-1:0]    rdAddr,
  output logic [IOC_DW-1:0]    rdData,
  input  logic [NUM_LINES-1:0] pendingIn,
  input  logic [NUM_LINES-1:0] levelIn,
  output logic [NUM_LINES-1:0] dirQ,
  output logic [NUM_LINES-1:0] maskQ,
  output logic [NUM_LINES-1:0] perEnQ,
  output logic [TIME_W-1:0]    pTimeQ,
  output lineStrobeS           strb
);
  localparam int SETTLE_CYC = 3;
  localparam int SETTLE_W   = $clog2(SETTLE_CYC + 1);

  logic [SETTLE_W-1:0] settleCnt;
  logic                settling;

  assign settling = (settleCnt != SETTLE_W'(SETTLE_CYC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (settling) begin
      settleCnt <= settleCnt + SETTLE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ   <= '0;
      maskQ  <= '0;
      perEnQ <= '0;
      pTimeQ <= '0;
    end else if (wrEn) begin
      case (regAddrE'(wrAddr))
        REG_DIR:   dirQ   <= wrData[NUM_LINES-1:0];
        REG_MASK:  maskQ  <= wrData[NUM_LINES-1:0] & MASK_IMPL;
        REG_PEN:   perEnQ <= wrData[NUM_LINES-1:0];
        REG_PTIME: pTimeQ <= wrData[TIME_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.settling  = settling;
    strb.clrStrobe = wrEn && (regAddrE'(wrAddr) == REG_PEND);
    strb.clrBits   = wrData;
  end

  always_comb begin
    rdData = '0;
    case (regAddrE'(rdAddr))
      REG_DIR:   rdData[NUM_LINES-1:0] = dirQ;
      REG_MASK:  rdData[NUM_LINES-1:0] = maskQ;
      REG_PEN:   rdData[NUM_LINES-1:0] = perEnQ;
      REG_PTIME: rdData[TIME_W-1:0]    = pTimeQ;
      REG_PEND:  rdData[NUM_LINES-1:0] = pendingIn;
      REG_LEVEL: rdData[NUM_LINES-1:0] = levelIn;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/ioc_lines.sv
module ioc_lines
  import ioc_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int TIME_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pinIn,
  input  logic                 tick,
  input  logic [NUM_LINES-1:0] dirQ,
  input  logic [NUM_LINES-1:0] maskQ,
  input  logic [NUM_LINES-1:0] perEnQ,
  input  logic [TIME_W-1:0]    pTimeQ,
  input  lineStrobeS           strb,
  output logic [NUM_LINES-1:0] pending,
  output logic [NUM_LINES-1:0] level
);
  logic [NUM_LINES-1:0] setBits;
  logic [NUM_LINES-1:0] clrBits;
  logic                 timeZero;
  logic [TIME_W-1:0]    lastCount;

  assign timeZero  = (pTimeQ == '0);
  assign lastCount = pTimeQ - TIME_W'(1);

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic              syncA, syncB, acc;
    logic [TIME_W-1:0] cnt;
    logic              persist, differ, track, accept;

    always_comb begin
      persist = perEnQ[g] && !timeZero;
      differ  = (syncB != acc);
      track   = strb.settling || dirQ[g];
      accept  = !track && differ && (!persist || (tick && (cnt >= lastCount)));
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
        acc   <= 1'b0;
        cnt   <= '0;
      end else begin
        syncA <= pinIn[g];
        syncB <= syncA;
        if (track) begin
          acc <= syncB;
          cnt <= '0;
        end else if (!differ) begin
          cnt <= '0;
        end else if (accept) begin
          acc <= syncB;
          cnt <= '0;
        end else if (persist && tick) begin
          cnt <= cnt + TIME_W'(1);
        end
      end
    end

    assign setBits[g] = accept && !maskQ[g];
    assign level[g]   = acc;
  end

  assign clrBits = strb.clrStrobe ? strb.clrBits[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= '0;
    else       pending <= (pending & ~clrBits) | setBits;
  end
endmodule

// File: rtl/ioc_irq_gen.sv
module ioc_irq_gen
  import ioc_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int TIME_W    = 8,
  parameter logic [NUM_LINES-1:0] MASK_IMPL = 8'hF5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pinIn,
  input  logic                 tick,
  input  logic                 wrEn,
  input  logic [2:0]           wrAddr,
  input  logic [7:0]           wrData,
  input  logic [2:0]           rdAddr,
  output logic [7:0]           rdData,
  output logic [NUM_LINES-1:0] pending,
  output logic                 irq
);
  logic [NUM_LINES-1:0] dirQ, maskQ, perEnQ, level;
  logic [TIME_W-1:0]    pTimeQ;
  lineStrobeS           strb;

  ioc_regs #(
    .NUM_LINES(NUM_LINES), .TIME_W(TIME_W), .MASK_IMPL(MASK_IMPL)
  ) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pendingIn(pending), .levelIn(level),
    .dirQ(dirQ), .maskQ(maskQ), .perEnQ(perEnQ), .pTimeQ(pTimeQ), .strb(strb)
  );

  ioc_lines #(
    .NUM_LINES(NUM_LINES), .TIME_W(TIME_W)
  ) uLines (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .tick(tick), .dirQ(dirQ),
    .maskQ(maskQ), .perEnQ(perEnQ), .pTimeQ(pTimeQ), .strb(strb),
    .pending(pending), .level(level)
  );

  assign irq = |pending;
endmodule

// File: rtl/ioc_irq_gen_chk.sv
module ioc_irq_gen_chk #(
  parameter int NUM_LINES = 8,
  parameter int TIME_W    = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 tick,
  input logic                 wrEn,
  input logic [2:0]           wrAddr,
  input logic [7:0]           wrData,
  input logic [NUM_LINES-1:0] pending,
  input logic [NUM_LINES-1:0] dirQ,
  input logic [NUM_LINES-1:0] maskQ,
  input logic [NUM_LINES-1:0] perEnQ,
  input logic [TIME_W-1:0]    pTimeQ,
  input logic                 settling
);
  logic [NUM_LINES-1:0] clrReq, persistLines;

  assign clrReq       = (wrEn && wrAddr == 3'd4) ? wrData[NUM_LINES-1:0] : '0;
  assign persistLines = perEnQ & {NUM_LINES{pTimeQ != '0}};

  AST_OUTPUT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ((pending & ~$past(pending) & $past(dirQ)) == '0)); // R2

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    ((pending & ~$past(pending) & $past(maskQ)) == '0)); // R3

  AST_PERSIST_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ((pending & ~$past(pending) & $past(persistLines) & ~{NUM_LINES{$past(tick)}}) == '0)); // R5

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((~pending & $past(pending) & ~$past(clrReq)) == '0)); // R8

  AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((pending & ~$past(pending) & {NUM_LINES{$past(settling)}}) == '0)); // R10
endmodule

bind ioc_irq_gen ioc_irq_gen_chk #(.NUM_LINES(NUM_LINES), .TIME_W(TIME_W)) uChk (
  .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .pending(pending), .dirQ(dirQ), .maskQ(maskQ),
  .perEnQ(perEnQ), .pTimeQ(pTimeQ), .settling(strb.settling)
);

// File: tb/sim_ioc_irq_gen.sv
module sim_ioc_irq_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pinReg = 8'h20;
  logic       tick = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [7:0] pending;
  logic       irq;
  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  ioc_irq_gen u0 (
    .clk(clk), .rstN(rstN), .pinIn(pinReg), .tick(tick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .pending(pending), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdCheck(input string tag, input logic [2:0] a, input logic [7:0] exp);
    rdAddr = a;
    #1;
    check(tag, rdData, exp);
  endtask

  task automatic pulseTick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    cyc(1);
  endtask

  task automatic t_reset();
    check("R10 pending after reset", pending, 8'h00);
    check("R9 irq after reset", irq, 1'b0);
    rdCheck("R11 dir reset", 3'd0, 8'h00);
    rdCheck("R11 mask reset", 3'd1, 8'h00);
    rdCheck("R11 pen reset", 3'd2, 8'h00);
    rdCheck("R11 ptime reset", 3'd3, 8'h00);
    rdCheck("R11 pend reset", 3'd4, 8'h00);
    rdCheck("R10 level loaded", 3'd5, 8'h20);
    rdCheck("R11 addr6", 3'd6, 8'h00);
  endtask

  task automatic t_immediate();
    pinReg[0] = 1'b1;
    cyc(2);
    check("R1 not yet after 2 edges", pending, 8'h00);
    cyc(1);
    check("R1 rise sets pending", pending, 8'h01);
    check("R9 irq high", irq, 1'b1);
    wrReg(3'd4, 8'h01);
    check("R8 w1c clears", pending, 8'h00);
    check("R9 irq low", irq, 1'b0);
    pinReg[0] = 1'b0;
    cyc(3);
    check("R1 fall sets pending", pending, 8'h01);
    wrReg(3'd4, 8'h01);
  endtask

  task automatic t_sticky();
    pinReg[2] = 1'b1;
    cyc(3);
    check("R1 line2 pending", pending, 8'h04);
    wrReg(3'd4, 8'h01);
    check("R8 other bit write leaves", pending, 8'h04);
    wrReg(3'd4, 8'h04);
    check("R8 clear line2", pending, 8'h00);
    pinReg[2] = 1'b0;
    cyc(2);
    wrReg(3'd4, 8'h04);
    check("R8 set wins over clear", pending, 8'h04);
    wrReg(3'd4, 8'h04);
  endtask

  task automatic t_output();
    wrReg(3'd0, 8'h10);
    pinReg[4] = 1'b1;
    cyc(5);
    check("R2 output line silent", pending, 8'h00);
    rdCheck("R2 output level tracked", 3'd5, 8'h30);
    wrReg(3'd0, 8'h00);
    cyc(5);
    check("R2 back to input no irq", pending, 8'h00);
  endtask

  task automatic t_mask();
    wrReg(3'd1, 8'h01);
    pinReg[0] = 1'b1;
    cyc(5);
    check("R3 masked line silent", pending, 8'h00);
    rdCheck("R3 masked level updated", 3'd5, 8'h31);
    wrReg(3'd1, 8'h00);
    cyc(5);
    check("R3 unmask no late irq", pending, 8'h00);
  endtask

  task automatic t_unimpl();
    wrReg(3'd1, 8'hFF);
    rdCheck("R4 mask readback", 3'd1, 8'hF5);
    pinReg[1] = 1'b1;
    cyc(3);
    check("R4 unbuilt mask no effect", pending, 8'h02);
    wrReg(3'd4, 8'h02);
    wrReg(3'd1, 8'h00);
  endtask

  task automatic t_persist();
    wrReg(3'd3, 8'd3);
    wrReg(3'd2, 8'h40);
    pinReg[6] = 1'b1;
    cyc(4);
    check("R5 no change before tick", pending, 8'h00);
    pulseTick();
    pulseTick();
    check("R5 none after 2 ticks", pending, 8'h00);
    pulseTick();
    check("R5 set at 3rd tick", pending, 8'h40);
    wrReg(3'd4, 8'h40);
  endtask

  task automatic t_glitch();
    pinReg[6] = 1'b0;
    cyc(4);
    pulseTick();
    pulseTick();
    pinReg[6] = 1'b1;
    cyc(4);
    pinReg[6] = 1'b0;
    cyc(4);
    pulseTick();
    pulseTick();
    check("R6 count restarted", pending, 8'h00);
    pinReg[6] = 1'b1;
    cyc(4);
    pulseTick();
    pulseTick();
    pulseTick();
    check("R6 return is no change", pending, 8'h00);
    rdAddr = 3'd5;
    #1;
    check("R6 level kept", rdData[6], 1'b1);
  endtask

  task automatic t_zero();
    wrReg(3'd3, 8'd0);
    pinReg[6] = 1'b0;
    cyc(3);
    check("R7 ptime zero immediate", pending, 8'h40);
    wrReg(3'd4, 8'h40);
    wrReg(3'd3, 8'd3);
    wrReg(3'd2, 8'h00);
    pinReg[7] = 1'b1;
    cyc(3);
    check("R7 enable off immediate", pending, 8'h80);
    wrReg(3'd4, 8'h80);
  endtask

  task automatic finishUp();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    finishUp();
  end

  initial begin
    cyc(4);
    rstN = 1'b1;
    cyc(6);
    t_reset();
    t_immediate();
    t_sticky();
    t_output();
    t_mask();
    t_unimpl();
    t_persist();
    t_glitch();
    t_zero();
    finishUp();
  end
endmodule